// File: doc/BRIEF.md
# Interleaved I/Q Polyphase Decimate-by-25 Filter

This block is the low-pass and rate-reduction stage that follows the mixer of a digital down-converter. In-phase and quadrature samples share one input stream and alternate word by word, so the stream runs at twice the per-channel sample rate. A tag bit on each word says which channel it belongs to. The block applies a 184-tap low-pass prototype and keeps one output in twenty-five per channel. Its output stream carries interleaved I and Q results with a valid strobe and a channel tag.

The datapath is a chain of eight multiply-accumulate stages. Each stage owns a 25-entry slice of the zero-padded 200-tap response, held as a constant ROM and addressed by a phase counter that steps once per I/Q pair. Each stage keeps one running sum per channel. At every block boundary a stage takes over the finished sum of the stage before it, so a partial result moves one stage along every 50 input clocks. The last stage's finished sum is shifted down, clipped to the output width and registered.

Top module: `iq_poly_decim`

## Requirements
- R1: While reset is asserted, out_valid, out_chan and out_data are all 0. After reset, every filter output is computed as if all samples before reset were zero.
- R2: An accepted word with in_chan = 0 is an I sample and one with in_chan = 1 is a Q sample. The coefficient phase steps by one after each accepted Q word and wraps to 0 after phase 24, so a block is 25 I/Q pairs.
- R3: For each channel, exactly one output per block appears, with out_valid high for one clock. It comes on the clock after the edge that accepts that channel's 25th word of the block, and out_chan equals that word's in_chan. This gives I then Q.
- R4: Output m of channel c equals floor(S / 2^19), saturated as in R6, where S = sum over k = 0..199 of h[k]·x_c[25m+24−k]. Here x_c[n] is the n-th accepted sample of channel c since reset, taken as zero for n < 0.
- R5: h[k] = 64·min(k+1, 184−k) for 0 ≤ k < 184, and h[k] = 0 for 184 ≤ k < 200.
- R6: The shifted sum is clipped to the signed 16-bit range [−32768, 32767]. A steady input of 32767 gives 32767, and a steady input of −32768 gives −32768.
- R7: A clock with in_valid = 0 has no effect. in_data and in_chan are ignored, the phase and sums hold, and no output is produced on that clock or the next.
- R8: The channels are independent: samples of one channel never change the results of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one input word per cycle at most |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input word strobe |
| in_chan | input | 1 | Channel of the input word: 0 = I, 1 = Q |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | One-clock strobe per decimated result |
| out_chan | output | 1 | Channel of the result: 0 = I, 1 = Q |
| out_data | output | 16 | Signed decimated result |

## Verification
The bench first flushes the filter with zeros and then sends a single impulse on I. A design with a mis-ordered ROM, a wrong stage lag or a wrong phase address shows the error in the impulse response, and the zero Q channel would pick up any cross-channel leak. Steady full-scale inputs of both signs check the clipping: a design that wraps instead of saturating returns a value of the wrong sign. A segment with idle clocks between pairs, carrying garbage data and tags, catches a design that counts phases or accumulates without the valid strobe. A reset in the middle of a block catches sums or phase state that survive reset, because the outputs that follow would then be shifted or polluted.

// File: rtl/iq_poly_decim_pkg.sv
package iq_poly_decim_pkg;

  // Triangular low-pass prototype, zero beyond the real tap count.
  function automatic int tap_coef(input int k, input int taps, input int step);
    int rise;
    int fall;
    if (k < 0 || k >= taps) return 0;
    rise = k + 1;
    fall = taps - k;
    return step * ((rise < fall) ? rise : fall);
  endfunction

  typedef enum logic { CH_I = 1'b0, CH_Q = 1'b1 } chan_e;

endpackage

// File: rtl/iq_rst_sync.sv
module iq_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/iq_phase_ctrl.sv
module iq_phase_ctrl #(
  parameter int DEC = 25,
  localparam int PW = $clog2(DEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          chan,
  output logic [PW-1:0] phase,
  output logic          blk_first,
  output logic          blk_last
);

  logic [PW-1:0] phase_nxt;

  assign blk_first = (phase == '0);
  assign blk_last  = (phase == PW'(DEC - 1));

  // Phase steps after the Q word of each pair.
  always_comb begin
    phase_nxt = phase;
    if (en && chan) begin
      phase_nxt = blk_last ? '0 : phase + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase_nxt;
  end

endmodule

// File: rtl/iq_mac_stage.sv
module iq_mac_stage
  import iq_poly_decim_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int AW   = 40,
  parameter int DEC  = 25,
  parameter int LAG  = 0,
  parameter int TAPS = 184,
  parameter int STEP = 64,
  localparam int PW  = $clog2(DEC),
  localparam int PRW = DW + CW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 chan,
  input  logic [PW-1:0]        phase,
  input  logic                 blk_first,
  input  logic signed [DW-1:0] din,
  input  logic signed [AW-1:0] carry_i,
  input  logic signed [AW-1:0] carry_q,
  output logic signed [AW-1:0] acc_i,
  output logic signed [AW-1:0] acc_q,
  output logic signed [AW-1:0] sum_nxt
);

  function automatic logic [DEC*CW-1:0] build_rom();
    logic [DEC*CW-1:0] r;
    r = '0;
    for (int p = 0; p < DEC; p++) begin
      r[p*CW +: CW] = CW'(tap_coef(LAG * DEC + DEC - 1 - p, TAPS, STEP));
    end
    return r;
  endfunction

  localparam logic [DEC*CW-1:0] ROM = build_rom();

  logic signed [CW-1:0]  coef;
  logic signed [PRW-1:0] prod;
  logic signed [AW-1:0]  prod_x;
  logic signed [AW-1:0]  base;
  logic signed [AW-1:0]  acc_i_nxt;
  logic signed [AW-1:0]  acc_q_nxt;

  assign coef   = ROM[phase*CW +: CW];
  assign prod   = din * coef;
  assign prod_x = {{(AW-PRW){prod[PRW-1]}}, prod};

  // A block starts from the finished sum handed down by the previous stage.
  always_comb begin
    if (blk_first) base = chan ? carry_q : carry_i;
    else           base = chan ? acc_q   : acc_i;
    sum_nxt   = base + prod_x;
    acc_i_nxt = acc_i;
    acc_q_nxt = acc_q;
    if (en) begin
      if (chan) acc_q_nxt = sum_nxt;
      else      acc_i_nxt = sum_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_i <= '0;
      acc_q <= '0;
    end else begin
      acc_i <= acc_i_nxt;
      acc_q <= acc_q_nxt;
    end
  end

endmodule

// File: rtl/iq_out_quant.sv
module iq_out_quant #(
  parameter int AW    = 40,
  parameter int OW    = 16,
  parameter int SHIFT = 19
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic                 chan,
  input  logic signed [AW-1:0] sum,
  output logic                 out_valid,
  output logic                 out_chan,
  output logic signed [OW-1:0] out_data
);

  logic signed [AW-1:0] shifted;
  logic                 fits;
  logic signed [OW-1:0] clipped;
  logic                 valid_nxt;
  logic                 chan_nxt;
  logic signed [OW-1:0] data_nxt;

  assign shifted = sum >>> SHIFT;
  // In range when every bit above the output sign bit copies it.
  assign fits    = (&shifted[AW-1:OW-1]) || !(|shifted[AW-1:OW-1]);

  always_comb begin
    if (fits)               clipped = shifted[OW-1:0];
    else if (shifted[AW-1]) clipped = {1'b1, {(OW-1){1'b0}}};
    else                    clipped = {1'b0, {(OW-1){1'b1}}};
    valid_nxt = fire;
    chan_nxt  = fire ? chan : out_chan;
    data_nxt  = fire ? clipped : out_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= valid_nxt;
      out_chan  <= chan_nxt;
      out_data  <= data_nxt;
    end
  end

endmodule

// File: rtl/iq_poly_decim.sv
module iq_poly_decim #(
  parameter int DW        = 16,
  parameter int CW        = 16,
  parameter int OW        = 16,
  parameter int DEC       = 25,
  parameter int STAGES    = 8,
  parameter int TAPS      = 184,
  parameter int COEF_STEP = 64,
  parameter int SHIFT     = 19
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_chan,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic                 out_chan,
  output logic signed [OW-1:0] out_data
);

  localparam int PW = $clog2(DEC);
  localparam int AW = DW + CW + $clog2(DEC * STAGES);

  logic          rst_n_s;
  logic [PW-1:0] phase;
  logic          blk_first;
  logic          blk_last;

  logic signed [AW-1:0] acc_i [STAGES];
  logic signed [AW-1:0] acc_q [STAGES];
  logic signed [AW-1:0] sum_w [STAGES];

  iq_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  iq_phase_ctrl #(.DEC(DEC)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .en        (in_valid),
    .chan      (in_chan),
    .phase     (phase),
    .blk_first (blk_first),
    .blk_last  (blk_last)
  );

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic signed [AW-1:0] cin_i;
    logic signed [AW-1:0] cin_q;
    if (s == 0) begin : g_head
      assign cin_i = '0;
      assign cin_q = '0;
    end else begin : g_link
      assign cin_i = acc_i[s-1];
      assign cin_q = acc_q[s-1];
    end

    // Stage s carries the slice of taps that is STAGES-1-s blocks old.
    iq_mac_stage #(
      .DW(DW), .CW(CW), .AW(AW), .DEC(DEC),
      .LAG(STAGES - 1 - s), .TAPS(TAPS), .STEP(COEF_STEP)
    ) u_mac (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .en        (in_valid),
      .chan      (in_chan),
      .phase     (phase),
      .blk_first (blk_first),
      .din       (in_data),
      .carry_i   (cin_i),
      .carry_q   (cin_q),
      .acc_i     (acc_i[s]),
      .acc_q     (acc_q[s]),
      .sum_nxt   (sum_w[s])
    );
  end

  iq_out_quant #(.AW(AW), .OW(OW), .SHIFT(SHIFT)) u_out (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .fire      (in_valid && blk_last),
    .chan      (in_chan),
    .sum       (sum_w[STAGES-1]),
    .out_valid (out_valid),
    .out_chan  (out_chan),
    .out_data  (out_data)
  );

endmodule

// File: rtl/iq_poly_decim_chk.sv
module iq_poly_decim_chk #(
  parameter int DEC = 25,
  parameter int OW  = 16,
  localparam int PW = $clog2(DEC)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_chan,
  input logic [PW-1:0]        phase,
  input logic                 out_valid,
  input logic                 out_chan,
  input logic signed [OW-1:0] out_data
);

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_chan && phase == PW'(DEC - 1)) |=> (phase == '0)); // R2

  AST_PHASE_HOLD_ON_I: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_chan) |=> $stable(phase)); // R2

  AST_OUT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(in_valid) && $past(phase) == PW'(DEC - 1))); // R3

  AST_OUT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_chan == $past(in_chan))); // R3

  AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(phase))); // R7

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data)); // R3

endmodule

bind iq_poly_decim iq_poly_decim_chk #(.DEC(DEC), .OW(OW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_chan   (in_chan),
  .phase     (phase),
  .out_valid (out_valid),
  .out_chan  (out_chan),
  .out_data  (out_data)
);

// File: tb/iq_poly_decim_bench.sv
`timescale 1ns/1ps
module iq_poly_decim_bench;

  localparam int NBLK = 25;
  localparam int NTAP = 200;

  typedef struct packed {
    logic [3:0]         kind;
    logic signed [15:0] amp;
    logic [7:0]         blocks;
    logic [3:0]         gap;
  } seg_t;

  // kind: 0 zero, 1 DC, 2 impulse on I, 3 alternating, 4 ramp, 5 I only, 6 full-scale DC
  localparam seg_t SEGS [8] = '{
    '{4'd0, 16'sd0,     8'd9, 4'd0},
    '{4'd2, 16'sd16384, 8'd9, 4'd0},
    '{4'd1, 16'sd16384, 8'd9, 4'd0},
    '{4'd3, 16'sd12000, 8'd9, 4'd0},
    '{4'd4, 16'sd0,     8'd9, 4'd2},
    '{4'd5, 16'sd20000, 8'd9, 4'd0},
    '{4'd6, 16'sd32767, 8'd9, 4'd0},
    '{4'd6, 16'h8000,   8'd9, 4'd0}
  };

  logic               clk;
  logic               rst_n;
  logic               in_valid;
  logic               in_chan;
  logic signed [15:0] in_data;
  logic               out_valid;
  logic               out_chan;
  logic signed [15:0] out_data;

  int    n_checks;
  int    n_fail;
  int    stray;
  bit    done;
  int    hist [2][4096];
  int    cnt  [2];
  int    exp_val [1024];
  bit    exp_ch  [1024];
  string exp_tag [1024];
  int    wr;
  int    rd;
  string cur_tag;

  iq_poly_decim u_iq_poly_decim (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_chan   (in_chan),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_chan  (out_chan),
    .out_data  (out_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int bh(input int k);
    int a;
    int b;
    if (k >= 184) return 0;
    a = k + 1;
    b = 184 - k;
    return 64 * ((a < b) ? a : b);
  endfunction

  function automatic int model(input int c, input int m);
    longint s;
    int n;
    s = 0;
    for (int k = 0; k < NTAP; k++) begin
      n = m * NBLK + NBLK - 1 - k;
      if (n >= 0) s += longint'(bh(k)) * longint'(hist[c][n]);
    end
    s = s >>> 19;
    if (s > 32767)  s = 32767;
    if (s < -32768) s = -32768;
    return int'(s);
  endfunction

  function automatic int smp(input int kind, input int amp, input int c, input int j);
    case (kind)
      1, 6: return amp;
      2:    return (c == 0 && j == 0) ? amp : 0;
      3:    return (((j + c) % 2) == 1) ? -amp : amp;
      4:    return (c == 0) ? ((j * 97) % 8192) - 4096 : 4096 - ((j * 61) % 8192);
      5:    return (c == 0) ? amp : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string kind_tag(input int kind);
    case (kind)
      2:       return "R5";
      4:       return "R7";
      5:       return "R8";
      6:       return "R6";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic put_word(input int c, input int v);
    in_valid = 1'b1;
    in_chan  = c[0];
    in_data  = 16'(v);
    hist[c][cnt[c]] = v;
    cnt[c]++;
    if (cnt[c] % NBLK == 0) begin
      exp_val[wr] = model(c, cnt[c] / NBLK - 1);
      exp_ch[wr]  = c[0];
      exp_tag[wr] = cur_tag;
      wr++;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b0;
      in_chan  = i[0];
      in_data  = 16'h5a5a ^ 16'(i * 331);
      @(negedge clk);
    end
  endtask

  task automatic clear_model();
    for (int c = 0; c < 2; c++) begin
      cnt[c] = 0;
      for (int n = 0; n < 4096; n++) hist[c][n] = 0;
    end
    rd = wr;
  endtask

  // Output monitor: every strobe must match the oldest pending result.
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (rd == wr) begin
        stray++;
        check(1'b0, "R3 unexpected output", int'(out_data), 0);
      end else begin
        check(out_chan == exp_ch[rd], {exp_tag[rd], " channel tag (R3)"},
              int'(out_chan), int'(exp_ch[rd]));
        check(int'(out_data) == exp_val[rd], exp_tag[rd], int'(out_data), exp_val[rd]);
        rd++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_fail = 0; stray = 0; done = 1'b0; wr = 0; rd = 0;
    cur_tag = "R4";
    in_valid = 1'b0; in_chan = 1'b0; in_data = '0;
    rst_n = 1'b0;
    clear_model();
    repeat (3) @(negedge clk);
    // R1: outputs are cleared during reset
    check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    check(out_chan == 1'b0, "R1 out_chan in reset", int'(out_chan), 0);
    check(out_data == 16'sd0, "R1 out_data in reset", int'(out_data), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table-driven segments, each a whole number of blocks.
    for (int si = 0; si < 8; si++) begin
      cur_tag = kind_tag(int'(SEGS[si].kind));
      for (int j = 0; j < int'(SEGS[si].blocks) * NBLK; j++) begin
        put_word(0, smp(int'(SEGS[si].kind), int'(SEGS[si].amp), 0, j));
        put_word(1, smp(int'(SEGS[si].kind), int'(SEGS[si].amp), 1, j));
        idle(int'(SEGS[si].gap));
      end
    end
    idle(4);
    check(rd == wr, "R3 all results delivered", rd, wr);

    // R7: a long idle stretch with garbage on the inputs yields nothing.
    idle(80);
    check(stray == 0, "R7 output during idle", stray, 0);

    // R1: reset in the middle of a block clears phase and sums.
    cur_tag = "R1";
    for (int j = 0; j < 10; j++) begin
      put_word(0, 30000);
      put_word(1, -30000);
    end
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after mid reset", int'(out_valid), 0);
    check(out_data == 16'sd0, "R1 out_data after mid reset", int'(out_data), 0);
    clear_model();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int j = 0; j < 3 * NBLK; j++) begin
      put_word(0, 8000 + j * 10);
      put_word(1, -5000);
    end
    idle(4);
    check(rd == wr, "R1 results after reset delivered", rd, wr);
    check(stray == 0, "R2 no output before the 25th pair", stray, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule